// File: doc/BRIEF.md
# Two-Stage Threshold Energy Accumulator

This block turns a stream of signed instantaneous power samples into a running energy count. A power word arrives now and then with a valid strobe and is held. On every fast tick the held word is added to a wide signed residue. Because the tick is much faster than the sample rate, each word is added many times. When the residue reaches a programmable threshold in either direction, the block emits one signed unit pulse and takes the threshold back out of the residue, so the remainder carries into the next tick.

The second stage counts these pulses in a signed wrapping register. A read strobe copies that count to the read data output. If the clear-on-read enable is set, the count also restarts from zero at the same edge. One instance serves one channel. The threshold is an 8-bit code shifted up by a fixed number of zero bits.

Top module: `energy_accum`

## Requirements
- R1: The threshold equals the stored code shifted left by THR_SHIFT bits. The stored code resets to 3 and is loaded from `thr_code` at an edge where `thr_we` is 1. The new code applies from the next edge onward.
- R2: A power word is stored at an edge where `pwr_vld` is 1. The stored word is added to the residue at every tick edge until it is replaced. A tick at the same edge as a new word still uses the previous word.
- R3: At a tick edge with a nonzero code, if residue plus power is at least the threshold, a positive pulse is produced and the residue keeps the sum minus the threshold.
- R4: At a tick edge with a nonzero code, if residue plus power is at most minus the threshold, a negative pulse is produced and the residue keeps the sum plus the threshold. `pulse_neg`=1 marks a negative pulse and `pulse_neg`=0 a positive one.
- R5: Each tick produces at most one pulse, and no pulse is produced without a tick. `pulse_vld` is 1 for exactly the cycle after the tick edge that produced the pulse. After reset it is 0.
- R6: While the stored code is 0, ticks produce no pulses and leave the residue unchanged.
- R7: The count rises by one for each positive pulse and falls by one for each negative pulse. It wraps from the largest positive value to the most negative value, and back the other way.
- R8: At an edge where `rd_stb` is 1, `rd_data` takes the count as it stood before any pulse at that same edge. `rd_data` then holds until the next read. After reset `rd_data` is 0.
- R9: A read with `rd_clr_en`=1 resets the count to 0. A pulse at the same edge is then applied on top of that zero, so no pulse is lost.
- R10: A read with `rd_clr_en`=0 leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_vld | input | 1 | Strobe that stores a new power word |
| pwr_in | input | PWR_W | Signed instantaneous power word |
| tick | input | 1 | Fast accumulation enable |
| thr_we | input | 1 | Loads the threshold code |
| thr_code | input | CODE_W | Unsigned threshold code |
| rd_stb | input | 1 | Read strobe for the energy count |
| rd_clr_en | input | 1 | Clears the count on each read when 1 |
| rd_data | output | CNT_W | Energy count captured at the last read |
| pulse_vld | output | 1 | One-cycle unit pulse from stage one |
| pulse_neg | output | 1 | Sign of the pulse, 1 for negative |

## Verification
The bench builds the block with PWR_W=12, THR_SHIFT=4 and CNT_W=8. The threshold unit is then 16, so power words of a few dozen produce a pulse every tick or two. The 8-bit count crosses its wrap points after only 128 pulses, which makes wrap in both directions cheap to test. Clear-on-read coinciding with a pulse is also easy to reach. Frozen residue under code 0 and several threshold changes fit into a few thousand random cycles.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/ea_residue.sv
module ea_residue
  import ea_pkg::*;
#(
  parameter int PWR_W     = 28,
  parameter int CODE_W    = 8,
  parameter int THR_SHIFT = 27,
  parameter int RES_W     = 40,
  parameter int RST_CODE  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pwr_vld,
  input  logic signed [PWR_W-1:0] pwr_in,
  input  logic                    tick,
  input  logic                    thr_we,
  input  logic [CODE_W-1:0]       thr_code,
  output step_e                   step,
  output logic [CODE_W-1:0]       thr_q
);
  localparam int PAD_W = RES_W - CODE_W - THR_SHIFT;

  logic signed [PWR_W-1:0] hold_q;
  logic signed [RES_W-1:0] res_q;
  logic signed [RES_W-1:0] sum;
  logic signed [RES_W-1:0] thr_full;

  // Widen the code into a full-width threshold.
  function automatic logic signed [RES_W-1:0] thr_value(input logic [CODE_W-1:0] c);
    return signed'({{PAD_W{1'b0}}, c, {THR_SHIFT{1'b0}}});
  endfunction

  // Pick the pulse direction from the sum and the threshold.
  function automatic step_e decide(input logic signed [RES_W-1:0] s,
                                   input logic signed [RES_W-1:0] t);
    if (t == '0)      return STEP_NONE;
    else if (s >= t)  return STEP_UP;
    else if (s <= -t) return STEP_DOWN;
    else              return STEP_NONE;
  endfunction

  assign thr_full = thr_value(thr_q);
  assign sum      = res_q + {{(RES_W-PWR_W){hold_q[PWR_W-1]}}, hold_q};
  assign step     = tick ? decide(sum, thr_full) : STEP_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      res_q  <= '0;
      thr_q  <= CODE_W'(RST_CODE);
    end else begin
      if (pwr_vld) hold_q <= pwr_in;
      if (thr_we)  thr_q  <= thr_code;
      if (tick && thr_q != '0) begin
        case (step)
          STEP_UP:   res_q <= sum - thr_full;
          STEP_DOWN: res_q <= sum + thr_full;
          default:   res_q <= sum;
        endcase
      end
    end
  end
endmodule

// File: rtl/ea_counter.sv
module ea_counter
  import ea_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_e            step,
  input  logic             rd_stb,
  input  logic             rd_clr_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] rd_data
);
  logic [CNT_W-1:0] base;

  // Two's complement step; wrapping falls out of the fixed width.
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] b, input step_e s);
    case (s)
      STEP_UP:   return b + CNT_W'(1);
      STEP_DOWN: return b - CNT_W'(1);
      default:   return b;
    endcase
  endfunction

  assign base = (rd_stb && rd_clr_en) ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rd_data <= '0;
    end else begin
      if (rd_stb) rd_data <= cnt_q;
      cnt_q <= next_count(base, step);
    end
  end
endmodule

// File: rtl/energy_accum.sv
module energy_accum
  import ea_pkg::*;
#(
  parameter int PWR_W     = 28,
  parameter int CODE_W    = 8,
  parameter int THR_SHIFT = 27,
  parameter int CNT_W     = 32,
  parameter int RST_CODE  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pwr_vld,
  input  logic signed [PWR_W-1:0] pwr_in,
  input  logic                    tick,
  input  logic                    thr_we,
  input  logic [CODE_W-1:0]       thr_code,
  input  logic                    rd_stb,
  input  logic                    rd_clr_en,
  output logic [CNT_W-1:0]        rd_data,
  output logic                    pulse_vld,
  output logic                    pulse_neg
);
  localparam int THR_W = CODE_W + THR_SHIFT;
  localparam int RES_W = ((PWR_W > THR_W) ? PWR_W : THR_W) + 5;

  step_e             step;
  logic [CODE_W-1:0] thr_q;
  logic [CNT_W-1:0]  cnt_q;

  ea_residue #(
    .PWR_W(PWR_W), .CODE_W(CODE_W), .THR_SHIFT(THR_SHIFT),
    .RES_W(RES_W), .RST_CODE(RST_CODE)
  ) u_res (
    .clk(clk), .rst_n(rst_n), .pwr_vld(pwr_vld), .pwr_in(pwr_in),
    .tick(tick), .thr_we(thr_we), .thr_code(thr_code),
    .step(step), .thr_q(thr_q)
  );

  ea_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .rd_stb(rd_stb),
    .rd_clr_en(rd_clr_en), .cnt_q(cnt_q), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_vld <= 1'b0;
      pulse_neg <= 1'b0;
    end else begin
      pulse_vld <= (step != STEP_NONE);
      pulse_neg <= (step == STEP_DOWN);
    end
  end
endmodule

// File: rtl/ea_checker.sv
module ea_checker #(
  parameter int CNT_W  = 32,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              rd_stb,
  input logic              rd_clr_en,
  input logic              pulse_vld,
  input logic              pulse_neg,
  input logic [CODE_W-1:0] thr_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  rd_data
);
  assert_pulse_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_vld |-> $past(tick));

  assert_zero_code_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_vld |-> ($past(thr_q) != '0));

  assert_count_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_vld && !pulse_neg && !$past(rd_stb && rd_clr_en))
      |-> cnt_q == $past(cnt_q) + CNT_W'(1));

  assert_count_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_vld && pulse_neg && !$past(rd_stb && rd_clr_en))
      |-> cnt_q == $past(cnt_q) - CNT_W'(1));

  assert_count_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_vld && !$past(rd_stb && rd_clr_en)) |-> $stable(cnt_q));

  assert_read_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_data == $past(cnt_q));

  assert_clear_keeps_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_clr_en) |=>
      cnt_q == (pulse_vld ? (pulse_neg ? {CNT_W{1'b1}} : CNT_W'(1)) : '0));
endmodule

bind energy_accum ea_checker #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rd_stb(rd_stb), .rd_clr_en(rd_clr_en),
  .pulse_vld(pulse_vld), .pulse_neg(pulse_neg), .thr_q(thr_q),
  .cnt_q(cnt_q), .rd_data(rd_data)
);

// File: tb/energy_accum_test.sv
`timescale 1ns/1ps
module energy_accum_test;
  localparam int PW = 12;
  localparam int CW = 8;
  localparam int SH = 4;
  localparam int NW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_vld = 1'b0;
  logic signed [PW-1:0] pwr_in = '0;
  logic tick = 1'b0;
  logic thr_we = 1'b0;
  logic [CW-1:0] thr_code = '0;
  logic rd_stb = 1'b0;
  logic rd_clr_en = 1'b0;
  logic [NW-1:0] rd_data;
  logic pulse_vld, pulse_neg;

  int vectors = 0;
  int fails = 0;
  longint res_m, hold_m, thr_m, cnt_m, rd_m;
  logic exp_vld, exp_neg;

  energy_accum #(.PWR_W(PW), .CODE_W(CW), .THR_SHIFT(SH), .CNT_W(NW)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_vld(pwr_vld), .pwr_in(pwr_in), .tick(tick),
    .thr_we(thr_we), .thr_code(thr_code), .rd_stb(rd_stb), .rd_clr_en(rd_clr_en),
    .rd_data(rd_data), .pulse_vld(pulse_vld), .pulse_neg(pulse_neg)
  );

  always #2.5 clk = ~clk;

  function automatic longint wrap_cnt(input longint v);
    longint m = longint'(1) << NW;
    longint r = ((v % m) + m) % m;
    if (r >= m / 2) r = r - m;
    return r;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input bit pv, input longint p, input bit tk,
                     input bit we, input int code, input bit rd, input bit clr);
    longint sum, t, delta;
    @(negedge clk);
    pwr_vld = pv; pwr_in = PW'(p); tick = tk; thr_we = we; thr_code = CW'(code);
    rd_stb = rd; rd_clr_en = clr;
    exp_vld = 1'b0; exp_neg = 1'b0; delta = 0;
    if (tk && thr_m != 0) begin
      sum = res_m + hold_m;
      t = thr_m << SH;
      if (sum >= t)       begin exp_vld = 1'b1; delta = 1;  res_m = sum - t; end
      else if (sum <= -t) begin exp_vld = 1'b1; exp_neg = 1'b1; delta = -1; res_m = sum + t; end
      else res_m = sum;
    end
    if (pv) hold_m = p;
    if (we) thr_m = code;
    if (rd) rd_m = cnt_m;
    cnt_m = wrap_cnt(((rd && clr) ? 0 : cnt_m) + delta);
    @(posedge clk);
    #1;
    check(tag, longint'(pulse_vld), longint'(exp_vld));
    if (exp_vld) check(tag, longint'(pulse_neg), longint'(exp_neg));
    if (rd) check(clr ? "R9" : "R8", longint'($signed(rd_data)), rd_m);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    res_m = 0; hold_m = 0; thr_m = 3; cnt_m = 0; rd_m = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R8", longint'(rd_data), 0);
    check("R5", longint'(pulse_vld), 0);

    // R1: reset code 3 gives threshold 48; exactly 48 pulses at once
    cyc("R1", 1, 48, 0, 0, 0, 0, 0);
    cyc("R1", 0, 0, 1, 0, 0, 0, 0);
    cyc("R1", 0, 0, 0, 1, 4, 0, 0);
    // R2: same word added on repeated ticks, threshold now 64
    for (int i = 0; i < 6; i++) cyc("R2", 0, 0, 1, 0, 0, 0, 0);
    // R2: new word at a tick edge is not used by that tick
    cyc("R2", 1, -60, 1, 0, 0, 0, 0);
    // R4: negative pulses
    for (int i = 0; i < 8; i++) cyc("R4", 0, 0, 1, 0, 0, 0, 0);
    cyc("R10", 0, 0, 0, 0, 0, 1, 0);
    cyc("R10", 0, 0, 0, 0, 0, 1, 0);
    // R6: code 0 freezes everything
    cyc("R6", 1, 40, 0, 1, 0, 0, 0);
    for (int i = 0; i < 10; i++) cyc("R6", 0, 0, 1, 0, 0, 0, 0);
    cyc("R6", 0, 0, 0, 0, 0, 1, 0);
    // R9: clear-on-read with a pulse at the same edge
    cyc("R9", 1, 48, 0, 1, 3, 0, 0);
    for (int i = 0; i < 4; i++) cyc("R3", 0, 0, 1, 0, 0, 0, 0);
    cyc("R9", 0, 0, 1, 0, 0, 1, 1);
    cyc("R9", 0, 0, 0, 0, 0, 1, 0);
    // R7: wrap upward then downward
    cyc("R7", 1, 47, 0, 0, 0, 0, 0);
    for (int i = 0; i < 300; i++) cyc("R7", 0, 0, 1, 0, 0, (i % 50) == 49, 0);
    cyc("R7", 1, -47, 0, 0, 0, 0, 0);
    for (int i = 0; i < 600; i++) cyc("R7", 0, 0, 1, 0, 0, (i % 50) == 49, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit pv = ($urandom_range(7) == 0);
      longint p = longint'($urandom_range(94)) - 47;
      bit tk = $urandom_range(1);
      bit we = ($urandom_range(49) == 0);
      int code = ($urandom_range(4) == 0) ? 0 : int'($urandom_range(255, 3));
      bit rd = ($urandom_range(9) == 0);
      bit clr = $urandom_range(1);
      cyc("R3", pv, p, tk, we, code, rd, clr);
    end
    cyc("R8", 0, 0, 0, 0, 0, 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule